// File: doc/BRIEF.md
# MSI Capture Ring Controller

The block takes incoming message-signalled interrupt writes and logs each one as a 16-byte record in a ring that lives in system memory. For every message it accepts while enabled, it issues one memory write request to the ring base plus the current hardware write offset. Once memory takes that request, it moves the write offset one record forward, wrapping at the ring size. A cascade interrupt to the host stays high while records are waiting. Software drains records by moving the read offset.

Software sets the block up through a small indexed register port. The port holds a control word, a split base address, the software-owned read offset and the hardware-owned write offset. The control word picks one of four power-of-two ring sizes and enables full detection. When the ring is full, the block either drops new messages and raises a sticky overflow flag, or overwrites the oldest record.

Top module: `msi_ring_ctrl`

## Requirements
- R1: After reset, the control word, both offsets and the overflow flag read zero. `irq` and `mem_valid` are low and `msi_ready` is high.
- R2: Register indices on `reg_idx`:
  - 0 is control. Bit 0 is enable, bit 1 is full detection, bit 3 is interrupt enable, bit 4 is stop-on-full and bits 9:8 are the size code. Bit 16 is the overflow flag; writing 1 to it clears it.
  - 3 is the upper base word and 4 is the lower base word.
  - 5 is the read offset.
  - 6 is the write offset, which is read-only.
  - Every other index reads zero.
- R3: Each message accepted while enabled, and not dropped, produces exactly one memory request. Its address is base + write offset. `mem_data[31:0]` carries the message word, with the byte for the lowest address in bits 7:0 (little-endian). Bits 127:32 are zero.
- R4: The write offset advances by 16, modulo the ring size, only in the cycle where `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, the request holds steady.
- R5: The ring size is 2^(code+15) bytes. Both offsets are confined to that size and kept 16-byte aligned: a written read offset is ANDed with (size-1) with its low four bits cleared.
- R6: `irq` is high exactly when interrupt enable is set and the read offset differs from the write offset. Writing a read offset equal to the write offset drops it.
- R7: With enable clear, a message is accepted and discarded. No request is made and the write offset does not change.
- R8: The ring is full when write offset + 16 (wrapped) equals the read offset. If the ring is full and both full detection and stop-on-full are set, the message is dropped with no request, and the sticky overflow flag is set.
- R9: If the ring is full, full detection is set and stop-on-full is clear, the record is still written. The read offset also advances by 16, discarding the oldest record.
- R10: With full detection clear, no full condition exists. After one full ring of writes, the write offset equals the read offset again and `irq` drops.
- R11: While a request is outstanding, `msi_ready` is low and no further message is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` (combinational) |
| msi_valid | input | 1 | Message write present |
| msi_data | input | 32 | Message data word |
| msi_ready | output | 1 | Block can take a message |
| mem_valid | output | 1 | Memory write request valid |
| mem_addr | output | ADDR_W | Byte address of the 16-byte record |
| mem_data | output | 128 | Record contents, little-endian |
| mem_ready | input | 1 | Memory accepts the request |
| irq | output | 1 | Cascade interrupt to the host |

## Verification
A corrupted write offset shows up at once on the next memory request address, which the scoreboard compares to a reference offset computed in the bench. It also shows up in the `irq` level after the drain writes. A wrong full decision shows up in one of three ways: a missing or extra request on the memory port, the overflow bit in the control word, or a read offset that moved when it should not. Wrap errors stay hidden until the offset crosses the ring end, so the bench sends a full ring's worth of messages and checks that the offset returns to its starting value.

// File: rtl/msic_pkg.sv
package msic_pkg;
   localparam int REG_W          = 32;
   localparam int REC_W          = 128;
   localparam int REC_SHIFT      = 4;
   localparam int MIN_RING_SHIFT = 15;

   localparam logic [2:0] IX_CTRL    = 3'd0;
   localparam logic [2:0] IX_BASE_HI = 3'd3;
   localparam logic [2:0] IX_BASE_LO = 3'd4;
   localparam logic [2:0] IX_RD_OFS  = 3'd5;
   localparam logic [2:0] IX_WR_OFS  = 3'd6;

   localparam int CB_EN    = 0;
   localparam int CB_FULL  = 1;
   localparam int CB_IRQ   = 3;
   localparam int CB_STOP  = 4;
   localparam int CB_SIZE  = 8;
   localparam int CB_OVF   = 16;

   typedef struct packed {
      logic       run;
      logic       full_chk;
      logic       irq_on;
      logic       halt_full;
      logic [1:0] size_code;
   } ctrl_t;

   typedef enum logic {ENG_IDLE, ENG_BUSY} eng_state_t;
endpackage

// File: rtl/msic_csr.sv
module msic_csr
   import msic_pkg::*;
#(
   parameter int OFFS_W = 18,
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_idx,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [OFFS_W-1:0] ring_mask,
   input  logic [OFFS_W-1:0] wr_ofs,
   input  logic              ovf_set,
   input  logic              rd_bump,
   output ctrl_t             ctrl,
   output logic [ADDR_W-1:0] base,
   output logic [OFFS_W-1:0] rd_ofs
);
   localparam int HI_USED = ADDR_W - REG_W;

   ctrl_t              ctrl_q;
   logic [REG_W-1:0]   base_lo_q;
   logic [HI_USED-1:0] base_hi_q;
   logic [OFFS_W-1:0]  rd_q;
   logic               ovf_q;
   logic               wr_ctrl, wr_rd;

   assign wr_ctrl = reg_we && (reg_idx == IX_CTRL);
   assign wr_rd   = reg_we && (reg_idx == IX_RD_OFS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         base_lo_q <= '0;
         base_hi_q <= '0;
         rd_q      <= '0;
         ovf_q     <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.run       <= reg_wdata[CB_EN];
            ctrl_q.full_chk  <= reg_wdata[CB_FULL];
            ctrl_q.irq_on    <= reg_wdata[CB_IRQ];
            ctrl_q.halt_full <= reg_wdata[CB_STOP];
            ctrl_q.size_code <= reg_wdata[CB_SIZE+1:CB_SIZE];
         end
         if (reg_we && reg_idx == IX_BASE_LO) base_lo_q <= reg_wdata;
         if (reg_we && reg_idx == IX_BASE_HI) base_hi_q <= reg_wdata[HI_USED-1:0];
         if (wr_rd)
            rd_q <= reg_wdata[OFFS_W-1:0] & ring_mask;
         else if (rd_bump)
            rd_q <= (rd_q + OFFS_W'(16)) & ring_mask;
         if (ovf_set)
            ovf_q <= 1'b1;
         else if (wr_ctrl && reg_wdata[CB_OVF])
            ovf_q <= 1'b0;
      end
   end

   assign ctrl   = ctrl_q;
   assign base   = {base_hi_q, base_lo_q};
   assign rd_ofs = rd_q & ring_mask;

   always_comb begin
      reg_rdata = '0;
      case (reg_idx)
         IX_CTRL: begin
            reg_rdata[CB_EN]               = ctrl_q.run;
            reg_rdata[CB_FULL]             = ctrl_q.full_chk;
            reg_rdata[CB_IRQ]              = ctrl_q.irq_on;
            reg_rdata[CB_STOP]             = ctrl_q.halt_full;
            reg_rdata[CB_SIZE+1:CB_SIZE]   = ctrl_q.size_code;
            reg_rdata[CB_OVF]              = ovf_q;
         end
         IX_BASE_HI: reg_rdata = REG_W'(base_hi_q);
         IX_BASE_LO: reg_rdata = base_lo_q;
         IX_RD_OFS:  reg_rdata = REG_W'(rd_ofs);
         IX_WR_OFS:  reg_rdata = REG_W'(wr_ofs);
         default:    reg_rdata = '0;
      endcase
   end

   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q && !(wr_ctrl && reg_wdata[CB_OVF]) |=> ovf_q);
   p_rd_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_q[REC_SHIFT-1:0] == '0);
endmodule

// File: rtl/msic_wr_ofs.sv
module msic_wr_ofs
   import msic_pkg::*;
#(
   parameter int OFFS_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [OFFS_W-1:0] ring_mask,
   output logic [OFFS_W-1:0] wr_ofs,
   output logic [OFFS_W-1:0] wr_next
);
   logic [OFFS_W-1:0] wr_q;

   assign wr_ofs  = wr_q & ring_mask;
   assign wr_next = (wr_ofs + OFFS_W'(1 << REC_SHIFT)) & ring_mask;

   always_ff @(posedge clk) begin
      if (!rst_n)      wr_q <= '0;
      else if (commit) wr_q <= wr_next;
   end

   p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(wr_q));
   p_wr_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q[REC_SHIFT-1:0] == '0);
endmodule

// File: rtl/msic_engine.sv
module msic_engine
   import msic_pkg::*;
#(
   parameter int OFFS_W = 18,
   parameter int ADDR_W = 64,
   parameter int ID_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              halt_full,
   input  logic              full,
   input  logic [ADDR_W-1:0] base,
   input  logic [OFFS_W-1:0] wr_ofs,
   input  logic              msi_valid,
   input  logic [REG_W-1:0]  msi_data,
   output logic              msi_ready,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [REC_W-1:0]  mem_data,
   input  logic              mem_ready,
   output logic              commit,
   output logic              ovf_set,
   output logic              rd_bump
);
   eng_state_t        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [REC_W-1:0]  data_q;
   logic [REC_W-1:0]  record;
   logic              take, drop;

   generate
      if (ID_W == REG_W) begin : g_full_id
         assign record = {{(REC_W-REG_W){1'b0}}, msi_data};
      end else begin : g_narrow_id
         assign record = {{(REC_W-ID_W){1'b0}}, msi_data[ID_W-1:0]};
      end
   endgenerate

   assign msi_ready = (state_q == ENG_IDLE);
   assign mem_valid = (state_q == ENG_BUSY);
   assign mem_addr  = addr_q;
   assign mem_data  = data_q;
   assign take      = msi_valid && msi_ready;
   assign drop      = !run || (full && halt_full);
   assign ovf_set   = take && run && full && halt_full;
   assign commit    = mem_valid && mem_ready;
   assign rd_bump   = commit && full && !halt_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         case (state_q)
            ENG_IDLE: if (take && !drop) begin
               addr_q  <= base + ADDR_W'(wr_ofs);
               data_q  <= record;
               state_q <= ENG_BUSY;
            end
            ENG_BUSY: if (mem_ready) state_q <= ENG_IDLE;
            default:  state_q <= ENG_IDLE;
         endcase
      end
   end

   p_take_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take && !drop |=> mem_valid);
   p_req_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
   p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take && !run |=> !mem_valid);
   p_busy_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> !msi_ready);
endmodule

// File: rtl/msi_ring_ctrl.sv
module msi_ring_ctrl
   import msic_pkg::*;
#(
   parameter int OFFS_W = 18,
   parameter int ADDR_W = 64,
   parameter int ID_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_idx,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              msi_valid,
   input  logic [31:0]       msi_data,
   output logic              msi_ready,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [127:0]      mem_data,
   input  logic              mem_ready,
   output logic              irq
);
   localparam int MAX_SHIFT = MIN_RING_SHIFT + 3;

   generate
      if (OFFS_W < MAX_SHIFT || OFFS_W > REG_W) begin : g_bad_offs
         $error("OFFS_W must cover the largest ring and fit a register");
      end
      if (ADDR_W <= REG_W || ADDR_W > 2*REG_W) begin : g_bad_addr
         $error("ADDR_W must lie between 33 and 64");
      end
      if (ID_W < 16 || ID_W > REG_W) begin : g_bad_id
         $error("ID_W must lie between 16 and 32");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [ADDR_W-1:0] base;
   logic [OFFS_W-1:0] ring_mask, rd_ofs, wr_ofs, wr_next;
   logic              full, commit, ovf_set, rd_bump;

   assign ring_mask = ((OFFS_W'(1) << (MIN_RING_SHIFT + int'(ctrl.size_code))) - OFFS_W'(1))
                      & ~OFFS_W'((1 << REC_SHIFT) - 1);
   assign full = ctrl.full_chk && (wr_next == rd_ofs);
   assign irq  = ctrl.irq_on && (wr_ofs != rd_ofs);

   msic_csr #(.OFFS_W(OFFS_W), .ADDR_W(ADDR_W)) u_csr (
      .clk, .rst_n, .reg_we, .reg_idx, .reg_wdata, .reg_rdata,
      .ring_mask, .wr_ofs, .ovf_set, .rd_bump, .ctrl, .base, .rd_ofs);

   msic_wr_ofs #(.OFFS_W(OFFS_W)) u_wofs (
      .clk, .rst_n, .commit, .ring_mask, .wr_ofs, .wr_next);

   msic_engine #(.OFFS_W(OFFS_W), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_eng (
      .clk, .rst_n, .run(ctrl.run), .halt_full(ctrl.halt_full), .full,
      .base, .wr_ofs, .msi_valid, .msi_data, .msi_ready,
      .mem_valid, .mem_addr, .mem_data, .mem_ready,
      .commit, .ovf_set, .rd_bump);

   p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.irq_on |-> !irq);
endmodule

// File: tb/tb_msi_ring_ctrl.sv
module tb_msi_ring_ctrl;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [2:0]   reg_idx = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         msi_valid = 1'b0;
   logic [31:0]  msi_data = '0;
   logic         msi_ready;
   logic         mem_valid;
   logic [63:0]  mem_addr;
   logic [127:0] mem_data;
   logic         mem_ready = 1'b1;
   logic         irq;

   typedef struct {
      logic [63:0]  a;
      logic [127:0] d;
   } rec_t;

   rec_t  sb[$];
   int    n_chk = 0, n_fail = 0;
   int    rdy_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   bit    done = 0;

   logic [63:0] m_base = '0;
   logic [31:0] m_w = 0, m_r = 0;
   bit m_en, m_full, m_stop, m_irq;
   int m_sz = 0;

   always #5 clk = ~clk;

   msi_ring_ctrl dut (.*);

   function automatic logic [31:0] ring_mask(int sz);
      return ((32'h8000 << sz) - 1) & ~32'hF;
   endfunction

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #2;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
   end

   // monitor: scoreboard compare on accepted requests (R3, R4)
   always @(negedge clk) begin
      if (rst_n && mem_valid && mem_ready) begin
         if (sb.size() == 0) chk("R3 unexpected request", {64'h0, mem_addr}, 128'h0);
         else begin
            rec_t e;
            e = sb.pop_front();
            chk("R3 addr", {64'h0, mem_addr}, {64'h0, e.a});
            chk("R3 data", mem_data, e.d);
         end
      end
   end

   task automatic wr(logic [2:0] i, logic [31:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_idx = i; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(string req, logic [2:0] i, logic [31:0] exp);
      @(negedge clk);
      reg_idx = i;
      #1 chk(req, {96'h0, reg_rdata}, {96'h0, exp});
   endtask

   task automatic set_ctrl(bit en, bit fl, bit ir, bit st, int sz);
      m_en = en; m_full = fl; m_irq = ir; m_stop = st; m_sz = sz;
      wr(3'd0, {22'h0, 2'(sz), 3'b0, st, ir, 1'b0, fl, en});
      m_w &= ring_mask(sz); m_r &= ring_mask(sz);
   endtask

   task automatic set_rd(logic [31:0] v);
      wr(3'd5, v);
      m_r = v & ring_mask(m_sz);
   endtask

   task automatic send(logic [31:0] d);
      logic [31:0] nx;
      bit fb, dr;
      rec_t e;
      nx = (m_w + 16) & ring_mask(m_sz);
      fb = m_full && (nx == m_r);
      dr = !m_en || (fb && m_stop);
      if (!dr) begin
         e.a = m_base + 64'(m_w);
         e.d = {96'h0, d};
         sb.push_back(e);
      end
      @(negedge clk);
      while (!msi_ready) @(negedge clk);
      msi_valid = 1'b1; msi_data = d;
      @(negedge clk);
      msi_valid = 1'b0;
      while (!msi_ready) @(negedge clk);
      if (!dr) begin
         m_w = nx;
         if (fb) m_r = (m_r + 16) & ring_mask(m_sz);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      chk("R1 irq", {127'h0, irq}, 0);
      chk("R1 mem_valid", {127'h0, mem_valid}, 0);
      chk("R1 msi_ready", {127'h0, msi_ready}, 1);
      rd("R1 ctrl", 3'd0, 0);
      rd("R1 rd ofs", 3'd5, 0);
      rd("R1 wr ofs", 3'd6, 0);

      // R2 register map
      wr(3'd3, 32'h0000_0001); wr(3'd4, 32'h8000_0000);
      m_base = 64'h1_8000_0000;
      set_ctrl(1, 0, 1, 0, 1);
      rd("R2 ctrl readback", 3'd0, 32'h0000_0109);
      rd("R2 base hi", 3'd3, 32'h1);
      rd("R2 base lo", 3'd4, 32'h8000_0000);
      rd("R2 unused index", 3'd1, 0);
      wr(3'd6, 32'h40);
      rd("R2 wr ofs read-only", 3'd6, 0);

      // R3/R4 basic logging, ready always high
      send(32'h0000_0011); send(32'hDEAD_BEEF); send(32'h0102_0304);
      rd("R4 wr ofs after 3", 3'd6, m_w);
      chk("R6 irq pending", {127'h0, irq}, 1);

      // R4 stalled memory port
      rdy_mode = 1;
      for (int i = 0; i < 6; i++) send(32'h100 + i);
      rdy_mode = 0;
      rd("R4 wr ofs after stalls", 3'd6, m_w);

      // R6 drain
      set_rd(m_w);
      chk("R6 irq after drain", {127'h0, irq}, 0);
      // R5 alignment/mask of read offset (size code 1, mask 0xFFF0)
      wr(3'd5, 32'h1234_5677);
      rd("R5 rd ofs masked", 3'd5, 32'h0000_5670);
      set_rd(m_w);

      // R11 busy blocks further messages
      rdy_mode = 2;
      begin
         rec_t e;
         e.a = m_base + 64'(m_w); e.d = {96'h0, 32'h5555_AAAA};
         sb.push_back(e);
      end
      @(negedge clk);
      msi_valid = 1'b1; msi_data = 32'h5555_AAAA;
      @(negedge clk);
      msi_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11 msi_ready low while busy", {127'h0, msi_ready}, 0);
      chk("R11 request held", {127'h0, mem_valid}, 1);
      rdy_mode = 0;
      while (!msi_ready) @(negedge clk);
      m_w = (m_w + 16) & ring_mask(m_sz);
      rd("R11 wr ofs", 3'd6, m_w);

      // R10 full ring wrap, size code 0, no full detection
      set_ctrl(1, 0, 1, 0, 0);
      set_rd(m_w);
      for (int i = 0; i < 2048; i++) send(32'h2000 + i);
      rd("R10 wr ofs back to start", 3'd6, m_r);
      chk("R10 irq low after full lap", {127'h0, irq}, 0);

      // R7 disabled discards
      set_ctrl(0, 0, 1, 0, 0);
      send(32'h7777);
      rd("R7 wr ofs unchanged", 3'd6, m_w);
      chk("R7 no request", {127'h0, mem_valid}, 0);

      // R8 stop on full
      set_ctrl(1, 1, 1, 1, 0);
      set_rd((m_w + 16) & ring_mask(0));
      send(32'h8888);
      rd("R8 wr ofs unchanged", 3'd6, m_w);
      rd("R8 overflow set", 3'd0, 32'h0001_001B);
      wr(3'd0, 32'h0001_001B);
      rd("R8 overflow cleared", 3'd0, 32'h0000_001B);

      // R9 overwrite oldest
      set_ctrl(1, 1, 1, 0, 0);
      send(32'h9999);
      rd("R9 wr ofs advanced", 3'd6, m_w);
      rd("R9 rd ofs pushed", 3'd5, m_r);
      chk("R9 rd one ahead", {96'h0, m_r}, {96'h0, (m_w + 32'd16) & ring_mask(0)});

      repeat (4) @(negedge clk);
      chk("R3 scoreboard empty", {96'h0, 32'(sb.size())}, 0);
      done = 1;
      summary();
   end
endmodule